// File: doc/BRIEF.md
# Lane-Predicated Vector Bit-Reverse Shift

This block takes a 128-bit source vector and splits it into lanes of 8, 16 or 32 bits. The same scalar amount is applied to every lane. Each lane is bit-reversed, and the reversed value is then shifted right so that only the `amount` bits that were lowest in the source lane remain, now in reversed order. An amount of zero clears the lane. An amount as large as the lane or larger leaves the lane fully reversed.

The result is merged into an old destination vector under a 16-bit byte-enable mask. Only enabled bytes take the new value; every other byte keeps the destination's previous content. The datapath is combinational, and one output register captures the merged vector on the clock edge where the valid strobe is high. Producing the mask and accessing the register file are handled by the surrounding logic.

Top module: `vec_bitrev_shift`

## Requirements
- R1: Only bits [7:0] of `shift_amt` form the amount; bits [31:8] have no effect (for example, 0x100 behaves as zero).
- R2: An amount of zero yields an all-zero result in every lane.
- R3: For 0 < amount < W, where W is the lane width, result bit k of a lane equals source lane bit (amount−1−k) for k < amount, and equals 0 for k ≥ amount.
- R4: For amount ≥ W, result bit k of a lane equals source lane bit (W−1−k), which is the full bit reversal.
- R5: `lane_sel` 0, 1 and 2 select lane widths of 8, 16 and 32 bits (16, 8 and 4 lanes). Code 3 behaves as 32-bit lanes.
- R6: Mask bit i controls result bits [8i+7:8i]. A bit of 1 takes the computed byte, and a bit of 0 keeps the byte from `dst_old`.
- R7: `res_vec` loads the merged result on the rising edge where `in_valid` is 1, and holds its value while `in_valid` is 0.
- R8: While `rst_n` is low, `res_vec` is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe for the merged result |
| src_vec | input | 128 | Source vector |
| dst_old | input | 128 | Old destination vector, used for masked bytes |
| shift_amt | input | 32 | Scalar amount; only the low 8 bits are used |
| lane_sel | input | 2 | Lane width code: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| byte_en | input | 16 | Per-byte write enable |
| res_vec | output | 128 | Registered merged result |

## Verification
The embedded assertions check these properties on every cycle:
- The register holds while `in_valid` is low.
- An all-zero mask returns the old destination.
- An amount of zero with every byte enabled gives zero.
- A fully enabled 8-bit lane with a large amount comes out mirrored.
- The reset value is zero.

The directed scenarios cover the cases that need a reference model. These are the exact shifted bit pattern for partial amounts in each lane width, code 3 acting as 32-bit lanes, the upper scalar bits being ignored, and mixed masks that merge new and old bytes.

// File: rtl/vec_bitrev_shift.sv
module vec_bitrev_shift #(
  parameter int VEC_W = 128,
  parameter int AMT_W = 32,
  parameter int USE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [VEC_W-1:0]     src_vec,
  input  logic [VEC_W-1:0]     dst_old,
  input  logic [AMT_W-1:0]     shift_amt,
  input  logic [1:0]           lane_sel,
  input  logic [VEC_W/8-1:0]   byte_en,
  output logic [VEC_W-1:0]     res_vec
);

  localparam int NB  = VEC_W / 8;
  localparam int NH  = VEC_W / 16;
  localparam int NW  = VEC_W / 32;

  logic [USE_W-1:0] amt;
  logic [VEC_W-1:0] res8, res16, res32, picked, merged;

  assign amt = shift_amt[USE_W-1:0];

  function automatic logic [31:0] rev_shift(input logic [31:0] v, input int unsigned w,
                                            input logic [USE_W-1:0] a);
    logic [31:0] r;
    int unsigned av;
    r  = '0;
    av = 32'(a);
    for (int k = 0; k < 32; k++)
      if (k < int'(w)) r[k] = v[5'(w - 1 - 32'(k))];
    if (av == 0)      return '0;
    else if (av < w)  return r >> (w - av);
    else              return r;
  endfunction

  for (genvar g = 0; g < NB; g++) begin : g_b8
    logic [31:0] t;
    assign t = rev_shift({24'b0, src_vec[g*8 +: 8]}, 8, amt);
    assign res8[g*8 +: 8] = t[7:0];
  end

  for (genvar g = 0; g < NH; g++) begin : g_h16
    logic [31:0] t;
    assign t = rev_shift({16'b0, src_vec[g*16 +: 16]}, 16, amt);
    assign res16[g*16 +: 16] = t[15:0];
  end

  for (genvar g = 0; g < NW; g++) begin : g_w32
    assign res32[g*32 +: 32] = rev_shift(src_vec[g*32 +: 32], 32, amt);
  end

  always_comb begin
    case (lane_sel)
      2'd0:    picked = res8;
      2'd1:    picked = res16;
      default: picked = res32;
    endcase
  end

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign merged[b*8 +: 8] = byte_en[b] ? picked[b*8 +: 8] : dst_old[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        res_vec <= '0;
    else if (in_valid) res_vec <= merged;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_vec)); // R7

  AST_MASK_OFF_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && byte_en == '0) |=> res_vec == $past(dst_old)); // R6

  AST_ZERO_AMT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shift_amt[USE_W-1:0] == '0 && byte_en == '1) |=> res_vec == '0); // R2

  AST_BYTE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sel == 2'd0 && shift_amt[USE_W-1:0] >= 8 && byte_en[0])
    |=> (res_vec[0] == $past(src_vec[7]) && res_vec[7] == $past(src_vec[0]))); // R4

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |=> res_vec == '0); // R8

endmodule

// File: tb/vec_bitrev_shift_bench.sv
module vec_bitrev_shift_bench;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         in_valid = 0;
  logic [127:0] src_vec = '0, dst_old = '0;
  logic [31:0]  shift_amt = '0;
  logic [1:0]   lane_sel = '0;
  logic [15:0]  byte_en = '0;
  logic [127:0] res_vec;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  vec_bitrev_shift u_vec_bitrev_shift (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .dst_old(dst_old), .shift_amt(shift_amt), .lane_sel(lane_sel),
    .byte_en(byte_en), .res_vec(res_vec));

  function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] o,
                                         input logic [31:0] am, input logic [1:0] sz,
                                         input logic [15:0] m);
    logic [127:0] r;
    int w, a, k, base;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    a = int'(am[7:0]);
    for (int b = 0; b < 128; b++) begin
      k = b % w;
      base = b - k;
      if (a == 0)     r[b] = 1'b0;
      else if (a < w) r[b] = (k < a) ? s[base + a - 1 - k] : 1'b0;
      else            r[b] = s[base + w - 1 - k];
      if (!m[b/8]) r[b] = o[b];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] exp);
    total++;
    if (res_vec !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, res_vec, exp);
    end
  endtask

  task automatic run_case(input string tag, input logic [127:0] s, input logic [127:0] o,
                          input logic [31:0] am, input logic [1:0] sz, input logic [15:0] m);
    @(negedge clk);
    src_vec = s; dst_old = o; shift_amt = am; lane_sel = sz; byte_en = m; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check(tag, model(s, o, am, sz, m));
  endtask

  task automatic t_reset();
    check("R8 reset", '0);
  endtask

  task automatic t_zero_amount();
    run_case("R2 zero amt 8b", 128'hDEADBEEF_01234567_89ABCDEF_FFFFFFFF, '1, 32'd0, 2'd0, 16'hFFFF);
    check("R2 all zero", '0);
    run_case("R1 amt 0x100 is zero", 128'hA5A5_5A5A_1111_2222_3333_4444_5555_6666, '1, 32'h100, 2'd2, 16'hFFFF);
    run_case("R1 upper bits ignored", 128'hCAFEBABE_0F0F0F0F_12345678_9ABCDEF0, '0, 32'hFFFF_FF03, 2'd1, 16'hFFFF);
  endtask

  task automatic t_partial();
    run_case("R3 8b amt 3", 128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10, '0, 32'd3, 2'd0, 16'hFFFF);
    run_case("R3 16b amt 5", 128'hF00F_1234_ABCD_0001_8000_7FFF_5555_AAAA, '0, 32'd5, 2'd1, 16'hFFFF);
    run_case("R3 32b amt 13", 128'h89ABCDEF_01234567_FFFF0000_0000FFFF, '0, 32'd13, 2'd2, 16'hFFFF);
    run_case("R3 16b amt 15", 128'h1357_9BDF_2468_ACE0_0F1E_2D3C_4B5A_6978, '0, 32'd15, 2'd1, 16'hFFFF);
  endtask

  task automatic t_full();
    run_case("R4 8b amt 8", 128'h0102_0408_1020_4080_F00F_C33C_A55A_9669, '0, 32'd8, 2'd0, 16'hFFFF);
    run_case("R4 16b amt 40", 128'h0001_8000_1234_5678_9ABC_DEF0_FEDC_BA98, '0, 32'd40, 2'd1, 16'hFFFF);
    run_case("R4 32b amt 255", 128'h00000001_80000000_12345678_DEADBEEF, '0, 32'd255, 2'd2, 16'hFFFF);
  endtask

  task automatic t_size3();
    run_case("R5 code3 as 32b amt 7", 128'h12345678_9ABCDEF0_0F0F0F0F_F0F0F0F0, '0, 32'd7, 2'd3, 16'hFFFF);
    run_case("R5 code3 as 32b amt 20", 128'hFEDCBA98_76543210_A5A5A5A5_00FF00FF, '0, 32'd20, 2'd3, 16'hFFFF);
  endtask

  task automatic t_mask();
    run_case("R6 mask none", 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
             128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 32'd4, 2'd0, 16'h0000);
    run_case("R6 mask alternating", 128'h1234_5678_9ABC_DEF0_1357_9BDF_2468_ACE0,
             128'hAAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0000_1111, 32'd9, 2'd1, 16'h5A3C);
    run_case("R6 mask low half", 128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF,
             128'h11111111_22222222_33333333_44444444, 32'd32, 2'd2, 16'h00FF);
  endtask

  task automatic t_hold();
    logic [127:0] exp;
    run_case("R7 load", 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0, '0, 32'd6, 2'd0, 16'hFFFF);
    exp = model(128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0, '0, 32'd6, 2'd0, 16'hFFFF);
    @(negedge clk);
    src_vec = '1; dst_old = '1; shift_amt = 32'd1; byte_en = 16'hFFFF; in_valid = 0;
    repeat (3) @(negedge clk);
    check("R7 hold while idle", exp);
  endtask

  initial begin : watchdog
    repeat (10000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_zero_amount();
    t_partial();
    t_full();
    t_size3();
    t_mask();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule